// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests for a small microcontroller core and hands the core one vector address at a time. Every source line is one of two kinds, fixed by a parameter mask. An event source latches its rising edge in a sticky flag. A level source requests only while its line is high and has no flag. A request counts only when its own enable bit and the global enable are both set. Among the requests that count, the lowest index wins. Index 0 belongs to reset, which is handled elsewhere, so line 0 never raises a request.

A three-state machine drives the core handshake. In RUN the controller may accept a request. In OFFER it holds `vec_valid` and a fixed `vec_addr` until the core pulses `cpu_ack`. In HOLDOFF it waits after a return-from-interrupt until one instruction of the interrupted program retires. The transitions are: RUN→OFFER on accept; OFFER→RUN on acknowledge; RUN→HOLDOFF on return; HOLDOFF→RUN on retire.

Acknowledge clears the global enable and the flag of the chosen source. A return sets the global enable again. Software can also set the global enable from inside a handler, which lets an enabled request preempt that handler. A register-style write port clears flags (write-one-to-clear), loads the enable mask and sets the relocation bit. The relocation bit moves the vector table from address 0 to a boot base.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset `vec_valid`, `gie` and every flag are 0, all source enables are 0 and the vector base is 0.
- R2: A source is accepted only when its enable bit (enable register, `reg_wr_sel`=1, bit i = source i) and `gie` are both 1 at the accepting clock edge.
- R3: Among the accepted candidates the lowest index wins. Index 0 never requests.
- R4: One cycle after acceptance `vec_valid` is 1 and `vec_addr` = base + index × VEC_STRIDE. Both stay unchanged until the cycle in which `cpu_ack` is high.
- R5: An acknowledge clears `gie`. A `cpu_reti` or `gie_set` pulse sets it. `gie_clr` has priority over both, and acknowledge has priority over setting.
- R6: On an event source a rising edge sets flag i (`flag_o` bit i). The flag holds while the source enable or `gie` is 0, and it is cleared by the acknowledge of that source.
- R7: A write with `reg_wr_sel`=0 clears each flag whose data bit is 1 and leaves flags whose data bit is 0 untouched. A new event in the same cycle keeps its flag set.
- R8: A level source requests only while its line is high and never sets a flag. If the line drops before the enables allow it, no vector is offered.
- R9: After `cpu_reti` no request is accepted until a `cpu_retire` pulse has been seen. The earliest offer appears two cycles after that pulse.
- R10: A `gie_clr` pulse blocks acceptance at the same edge, even for a request that arrives in that cycle.
- R11: A write with `reg_wr_sel`=2 loads data bit 0 into the relocation bit. When it is 1, the base is BOOT_BASE instead of 0. The base is sampled at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_SRC | Source lines; bit 0 reserved |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | 0 flag clear, 1 enable mask, 2 relocation, 3 none |
| reg_wr_data | input | NUM_SRC | Write data |
| cpu_ack | input | 1 | Core takes the offered vector |
| cpu_reti | input | 1 | Return-from-interrupt |
| cpu_retire | input | 1 | One instruction retired |
| gie_set | input | 1 | Set global enable |
| gie_clr | input | 1 | Clear global enable, immediate |
| vec_valid | output | 1 | Vector offered |
| vec_addr | output | ADDR_W | Offered vector address |
| vec_idx | output | IDX_W | Offered source index |
| gie | output | 1 | Global enable state |
| flag_o | output | NUM_SRC | Event flags |

## Verification
Directed sequences cover several cases:
- Two simultaneous event flags, which shows whether priority follows index order.
- A return followed by idle cycles and then a retire, which shows whether the hold-off waits for retirement or for time.
- A level line that rises together with a global-clear pulse, which separates the immediate block from a one-cycle-late one.
- A clear write that lands in the same cycle as a new event, which shows whether the event wins.

Constrained random traffic then mixes sparse line toggles, enable rewrites, relocation flips and handshake pulses. A reference model recomputes the offer, the address, the global enable and the flags on every cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_OFFER   = 2'd1,
        ST_HOLDOFF = 2'd2
    } irq_state_e;

    localparam logic [1:0] SEL_FLAG_CLR = 2'd0;
    localparam logic [1:0] SEL_ENABLE   = 2'd1;
    localparam logic [1:0] SEL_RELOC    = 2'd2;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
    parameter int                   NUM_SRC    = 8,
    parameter logic [NUM_SRC-1:0]   LEVEL_MASK = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [NUM_SRC-1:0] en_mask,
    input  logic [NUM_SRC-1:0] w1c_mask,
    input  logic [NUM_SRC-1:0] ack_mask,
    output logic [NUM_SRC-1:0] flag_q,
    output logic [NUM_SRC-1:0] pend
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        if (i == 0) begin : g_rsv
            // reset slot: never a request
            logic unused_rsv;
            assign unused_rsv = ^{src_in[i], en_mask[i], w1c_mask[i], ack_mask[i]};
            assign flag_q[i]  = 1'b0;
            assign pend[i]    = 1'b0;
        end else if (LEVEL_MASK[i]) begin : g_lvl
            logic unused_lvl;
            assign unused_lvl = ^{w1c_mask[i], ack_mask[i]};
            assign flag_q[i]  = 1'b0;
            assign pend[i]    = src_in[i] & en_mask[i];
        end else begin : g_evt
            logic prev_q;
            logic flag_r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    prev_q <= 1'b0;
                    flag_r <= 1'b0;
                end else begin
                    prev_q <= src_in[i];
                    // a new edge wins over any clear in the same cycle
                    flag_r <= (flag_r & ~w1c_mask[i] & ~ack_mask[i])
                            | (src_in[i] & ~prev_q);
                end
            end
            assign flag_q[i] = flag_r;
            assign pend[i]   = flag_r & en_mask[i];

            AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                flag_r && !w1c_mask[i] && !ack_mask[i] |=> flag_r); // R6
            AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
                src_in[i] && !prev_q |=> flag_r); // R7
        end
    end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] req,
    output logic               any_req,
    output logic [IDX_W-1:0]   win_idx,
    output logic [NUM_SRC-1:0] grant
);
    always_comb begin
        win_idx = '0;
        grant   = '0;
        // scan downward so the lowest set index is written last
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                win_idx = IDX_W'(i);
                grant   = NUM_SRC'(1) << i;
            end
        end
        any_req = |req;
    end
endmodule

// File: rtl/irq_vec_fsm.sv
module irq_vec_fsm
    import irq_pkg::*;
#(
    parameter int                NUM_SRC    = 8,
    parameter int                IDX_W      = 3,
    parameter int                ADDR_W     = 16,
    parameter int                VEC_STRIDE = 2,
    parameter logic [ADDR_W-1:0] BOOT_BASE  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              any_req,
    input  logic [IDX_W-1:0]  win_idx,
    input  logic              reloc,
    input  logic              cpu_ack,
    input  logic              cpu_reti,
    input  logic              cpu_retire,
    input  logic              gie_set,
    input  logic              gie_clr,
    output logic              vec_valid,
    output logic [ADDR_W-1:0] vec_addr,
    output logic [IDX_W-1:0]  vec_idx,
    output logic              gie,
    output logic              ack_fire
);
    localparam logic [ADDR_W-1:0] STRIDE_A = ADDR_W'(VEC_STRIDE);

    irq_state_e        st_q, st_d;
    logic              gie_q, gie_d;
    logic [ADDR_W-1:0] addr_q;
    logic [IDX_W-1:0]  idx_q;
    logic              take;
    logic [ADDR_W-1:0] base;

    assign take = gie_q && !gie_clr && !cpu_reti && any_req;
    assign base = reloc ? BOOT_BASE : '0;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN: begin
                if (cpu_reti)  st_d = ST_HOLDOFF;
                else if (take) st_d = ST_OFFER;
            end
            ST_OFFER: begin
                if (cpu_ack) st_d = ST_RUN;
            end
            ST_HOLDOFF: begin
                if (cpu_retire) st_d = ST_RUN;
            end
            default: st_d = ST_RUN;
        endcase
    end

    always_comb begin
        gie_d = gie_q;
        if (gie_clr)                         gie_d = 1'b0;
        else if (st_q == ST_OFFER && cpu_ack) gie_d = 1'b0;
        else if (cpu_reti || gie_set)        gie_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_RUN;
            gie_q  <= 1'b0;
            addr_q <= '0;
            idx_q  <= '0;
        end else begin
            st_q  <= st_d;
            gie_q <= gie_d;
            if (st_q == ST_RUN && st_d == ST_OFFER) begin
                idx_q  <= win_idx;
                addr_q <= base + ADDR_W'(win_idx) * STRIDE_A;
            end
        end
    end

    always_comb begin
        vec_valid = (st_q == ST_OFFER);
        ack_fire  = (st_q == ST_OFFER) && cpu_ack;
        vec_addr  = addr_q;
        vec_idx   = idx_q;
        gie       = gie_q;
    end

    AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_OFFER && !cpu_ack |=> st_q == ST_OFFER && $stable(addr_q)); // R4
    AST_ACK_DROPS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_OFFER && cpu_ack |=> !gie_q); // R5
    AST_CLR_BLOCKS_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q != ST_OFFER && gie_clr |=> st_q != ST_OFFER); // R10
    AST_HOLDOFF_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_HOLDOFF |=> st_q != ST_OFFER); // R9
    AST_TAKE_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_RUN && !gie_q |=> st_q != ST_OFFER); // R2
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_pkg::*;
#(
    parameter int                   NUM_SRC    = 8,
    parameter int                   ADDR_W     = 16,
    parameter int                   VEC_STRIDE = 2,
    parameter logic [ADDR_W-1:0]    BOOT_BASE  = 16'h0C00,
    parameter logic [NUM_SRC-1:0]   LEVEL_MASK = 8'hC0,
    localparam int                  IDX_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               reg_wr_en,
    input  logic [1:0]         reg_wr_sel,
    input  logic [NUM_SRC-1:0] reg_wr_data,
    input  logic               cpu_ack,
    input  logic               cpu_reti,
    input  logic               cpu_retire,
    input  logic               gie_set,
    input  logic               gie_clr,
    output logic               vec_valid,
    output logic [ADDR_W-1:0]  vec_addr,
    output logic [IDX_W-1:0]   vec_idx,
    output logic               gie,
    output logic [NUM_SRC-1:0] flag_o
);
    logic [NUM_SRC-1:0] en_q;
    logic               reloc_q;
    logic [NUM_SRC-1:0] w1c_mask;
    logic [NUM_SRC-1:0] ack_mask;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] grant;
    logic               any_req;
    logic [IDX_W-1:0]   win_idx;
    logic               ack_fire;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= '0;
            reloc_q <= 1'b0;
        end else if (reg_wr_en) begin
            if (reg_wr_sel == SEL_ENABLE) en_q    <= reg_wr_data;
            if (reg_wr_sel == SEL_RELOC)  reloc_q <= reg_wr_data[0];
        end
    end

    assign w1c_mask = (reg_wr_en && reg_wr_sel == SEL_FLAG_CLR) ? reg_wr_data : '0;
    assign ack_mask = ack_fire ? (NUM_SRC'(1) << vec_idx) : '0;

    irq_src_bank #(
        .NUM_SRC    (NUM_SRC),
        .LEVEL_MASK (LEVEL_MASK)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_in   (src_in),
        .en_mask  (en_q),
        .w1c_mask (w1c_mask),
        .ack_mask (ack_mask),
        .flag_q   (flag_o),
        .pend     (pend)
    );

    irq_prio_enc #(
        .NUM_SRC (NUM_SRC),
        .IDX_W   (IDX_W)
    ) u_prio (
        .req     (pend),
        .any_req (any_req),
        .win_idx (win_idx),
        .grant   (grant)
    );

    irq_vec_fsm #(
        .NUM_SRC    (NUM_SRC),
        .IDX_W      (IDX_W),
        .ADDR_W     (ADDR_W),
        .VEC_STRIDE (VEC_STRIDE),
        .BOOT_BASE  (BOOT_BASE)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_req    (any_req),
        .win_idx    (win_idx),
        .reloc      (reloc_q),
        .cpu_ack    (cpu_ack),
        .cpu_reti   (cpu_reti),
        .cpu_retire (cpu_retire),
        .gie_set    (gie_set),
        .gie_clr    (gie_clr),
        .vec_valid  (vec_valid),
        .vec_addr   (vec_addr),
        .vec_idx    (vec_idx),
        .gie        (gie),
        .ack_fire   (ack_fire)
    );

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && (any_req == (grant != '0))); // R3
    AST_IDX0_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> vec_idx != '0); // R3
    AST_GRANT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~en_q) == '0); // R2
endmodule

// File: tb/irq_vector_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb;
    localparam int          N      = 8;
    localparam int          AW     = 16;
    localparam int          STRIDE = 2;
    localparam logic [15:0] BOOT   = 16'h0C00;
    localparam logic [7:0]  LVL    = 8'hC0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src_in = '0;
    logic          reg_wr_en = 1'b0;
    logic [1:0]    reg_wr_sel = '0;
    logic [N-1:0]  reg_wr_data = '0;
    logic          cpu_ack = 1'b0, cpu_reti = 1'b0, cpu_retire = 1'b0;
    logic          gie_set = 1'b0, gie_clr = 1'b0;
    logic          vec_valid;
    logic [AW-1:0] vec_addr;
    logic [2:0]    vec_idx;
    logic          gie;
    logic [N-1:0]  flag_o;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    irq_vector_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .reg_wr_en(reg_wr_en),
        .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data), .cpu_ack(cpu_ack),
        .cpu_reti(cpu_reti), .cpu_retire(cpu_retire), .gie_set(gie_set),
        .gie_clr(gie_clr), .vec_valid(vec_valid), .vec_addr(vec_addr),
        .vec_idx(vec_idx), .gie(gie), .flag_o(flag_o)
    );

    // reference model: 0 run, 1 offer, 2 hold-off
    int            m_st;
    logic          m_gie;
    logic [N-1:0]  m_flag, m_en, m_prev;
    logic          m_reloc;
    logic [AW-1:0] m_addr;
    int            m_idx;

    function automatic int lowest(input logic [N-1:0] p);
        int w = -1;
        for (int i = N - 1; i >= 1; i--) if (p[i]) w = i;
        return w;
    endfunction

    function automatic logic [AW-1:0] vaddr(input logic rel, input int idx);
        return (rel ? BOOT : 16'h0000) + AW'(idx * STRIDE);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_gie = 1'b0; m_flag = '0; m_en = '0; m_prev = '0;
            m_reloc = 1'b0; m_addr = '0; m_idx = 0;
        end else begin
            logic [N-1:0] ev, pend, w1c, ackc, nflag;
            int win, nst;
            logic ngie, ack_ok, tk;
            ev   = src_in & ~m_prev & ~LVL;
            pend = ((m_flag & ~LVL) | (src_in & LVL)) & m_en & ~N'(1);
            win  = lowest(pend);
            ack_ok = (m_st == 1) && cpu_ack;
            ackc = ack_ok ? (N'(1) << m_idx) & ~LVL : '0;
            w1c  = (reg_wr_en && reg_wr_sel == 2'd0) ? reg_wr_data : '0;
            nflag = ((m_flag & ~w1c & ~ackc) | ev) & ~LVL & ~N'(1);
            tk = m_gie && !gie_clr && !cpu_reti && (win > 0);
            nst = m_st;
            if (m_st == 0) begin
                if (cpu_reti) nst = 2;
                else if (tk) begin
                    nst = 1; m_idx = win; m_addr = vaddr(m_reloc, win);
                end
            end else if (m_st == 1) begin
                if (cpu_ack) nst = 0;
            end else if (cpu_retire) nst = 0;
            ngie = m_gie;
            if (gie_clr) ngie = 1'b0;
            else if (ack_ok) ngie = 1'b0;
            else if (cpu_reti || gie_set) ngie = 1'b1;
            if (reg_wr_en && reg_wr_sel == 2'd1) m_en = reg_wr_data;
            if (reg_wr_en && reg_wr_sel == 2'd2) m_reloc = reg_wr_data[0];
            m_prev = src_in; m_flag = nflag; m_gie = ngie; m_st = nst;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk(vec_valid == (m_st == 1), "R4 vec_valid", 32'(vec_valid), 32'(m_st == 1));
        if (m_st == 1) begin
            chk(vec_addr == m_addr, "R4 vec_addr", 32'(vec_addr), 32'(m_addr));
            chk(vec_idx != 0, "R3 idx0", 32'(vec_idx), 32'(m_idx));
        end
        chk(gie == m_gie, "R5 gie", 32'(gie), 32'(m_gie));
        chk(flag_o == m_flag, "R6 flags", 32'(flag_o), 32'(m_flag));
    endtask

    task automatic tick();
        @(negedge clk);
        compare();
        cpu_ack = 0; cpu_reti = 0; cpu_retire = 0; gie_set = 0; gie_clr = 0;
        reg_wr_en = 0;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [N-1:0] d);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk(!vec_valid && !gie && flag_o == 0, "R1 reset", {vec_valid, gie, 8'h0, flag_o}, 0);
        wr(2'd1, 8'hFE); tick();
        src_in = 8'b0010_0100; tick();
        chk(flag_o == 8'h24, "R6 flags set while gie off", 32'(flag_o), 32'h24);
        chk(!vec_valid, "R2 gie off blocks", 32'(vec_valid), 0);
        gie_set = 1; tick();
        tick();
        chk(vec_valid && vec_addr == 16'd4, "R3 lowest index wins", 32'(vec_addr), 4);
        tick();
        chk(vec_valid && vec_addr == 16'd4, "R4 held until ack", 32'(vec_addr), 4);
        cpu_ack = 1; tick();
        chk(!gie && flag_o == 8'h20, "R5 ack clears gie and flag", {gie, flag_o}, 32'h20);
        cpu_reti = 1; tick();
        chk(gie, "R5 reti sets gie", 32'(gie), 1);
        tick();
        chk(!vec_valid, "R9 hold-off until retire", 32'(vec_valid), 0);
        cpu_retire = 1; tick();
        tick();
        chk(vec_valid && vec_addr == 16'd10, "R9 offer after retire", 32'(vec_addr), 10);
        cpu_ack = 1; tick();
        wr(2'd2, 8'h01); src_in[3] = 1'b1; tick();
        gie_set = 1; tick();
        tick();
        chk(vec_valid && vec_addr == 16'h0C06, "R11 relocated base", 32'(vec_addr), 32'h0C06);
        cpu_ack = 1; tick();
        wr(2'd2, 8'h00); gie_set = 1; tick();
        src_in[6] = 1'b1; gie_clr = 1; tick();
        chk(!vec_valid && !gie, "R10 clear blocks same-cycle request", {vec_valid, gie}, 0);
        tick();
        chk(flag_o[6] == 1'b0, "R8 level has no flag", 32'(flag_o), 0);
        src_in[6] = 1'b0; gie_set = 1; tick();
        tick();
        chk(!vec_valid, "R8 dropped level not taken", 32'(vec_valid), 0);
        src_in[4] = 1'b1; wr(2'd0, 8'h10); gie_clr = 1; tick();
        chk(flag_o[4], "R7 event beats clear", 32'(flag_o), 32'h10);
        wr(2'd0, 8'h00); tick();
        chk(flag_o[4], "R7 zero write no effect", 32'(flag_o), 32'h10);
        wr(2'd0, 8'h10); tick();
        chk(!flag_o[4], "R7 one write clears", 32'(flag_o), 0);
        src_in = '0; tick();

        // constrained random phase
        for (int c = 0; c < 3000; c++) begin
            src_in ^= N'($urandom & $urandom & $urandom);
            if ($urandom_range(9) == 0) wr(2'($urandom_range(3)), N'($urandom));
            if (m_st == 1) cpu_ack = ($urandom_range(2) == 0);
            else cpu_reti = ($urandom_range(19) == 0);
            cpu_retire = ($urandom_range(2) == 0);
            gie_set = ($urandom_range(7) == 0);
            gie_clr = ($urandom_range(15) == 0);
            tick();
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule